// File: doc/BRIEF.md
# Dual-Channel Serial Result Output Port

This block takes a pair of conversion results, each `RES_W` bits wide, and sends them out one bit at a time on a single data line. Both results sit in a single `2*RES_W`-bit shift register and leave most significant bit first. A select input chooses which result goes first. A conversion-done strobe copies a fresh pair into a holding register. A shift register is loaded from that holding register only when a read begins, so a read in progress never picks up new data halfway through.

When the block drives the clock itself, it divides the system clock down to make the serial clock. It also drives a frame signal whose polarity is selectable. That frame signal drops to its inactive level for one bit period where the second result begins. A read-mode input picks one of two behaviours. In the first, a read sends the pair already held while the next conversion runs. In the second, a read waits for the next conversion to finish and then sends the new pair. When the serial clock comes from outside, the block passes it through a synchroniser and shifts on the selected edge of it. It also feeds a chain input into the bottom of the shift register, so that several devices can share one data line.

Top module: `dual_result_serializer`

## Requirements
- R1: During and after reset, `sdout` and `read_done` are low, `sync_out` equals `sync_inv`, and `sclk_out` equals `sclk_inv`.
- R2: A frame is `2*RES_W` bits, most significant bit first. With `order_b_first` low the bits are `res_a` and then `res_b`. With it high they are `res_b` and then `res_a`. The order is taken when the read starts.
- R3: With `ext_clk_mode` low, each bit lasts `DIV` system clocks. `sdout` changes only at the start of a bit period. `sclk_out` is `1^sclk_inv` for the first `DIV/2` clocks of each bit period and `sclk_inv` for the rest. Between frames `sclk_out` rests at `sclk_inv`.
- R4: With `ext_clk_mode` low, `sync_out` is `1^sync_inv` while a frame is being sent and `sync_inv` otherwise. With `ext_clk_mode` high, `sync_out` stays at `sync_inv`.
- R5: During bit period number `RES_W`, which is the first bit of the second result, `sync_out` is at its inactive level `sync_inv`.
- R6: With `overlap_read` high, a `read_req` pulse starts a frame on the next clock using the held pair. A `conv_done` strobe during a frame does not change that frame, but the next read sends the new pair.
- R7: With `overlap_read` low, a `read_req` leaves the output idle until the next `conv_done`. The frame starts on the clock after that strobe and carries the pair presented with the strobe.
- R8: With `ext_clk_mode` high, a read loads the frame and presents its first bit. Each update edge of `sclk_in` advances `sdout` by one bit within four system clocks. The update edge is rising when `sclk_inv` is 0 and falling when it is 1. Sample edges leave `sdout` unchanged.
- R9: With `ext_clk_mode` high, the `chain_in` level captured at update edge k appears on `sdout` after update edge k+`2*RES_W`-1. Shifting carries on past the end of the frame until the next `read_req`.
- R10: `read_done` is high for exactly one system clock per read. With `ext_clk_mode` low this is the clock after the last bit period. With `ext_clk_mode` high it follows update edge number `2*RES_W`.
- R11: With `ext_clk_mode` low, `sdout` is low whenever no frame is being sent, including the clock in which `read_done` is high.
- R12: With `ext_clk_mode` low, a `read_req` that arrives during a frame is ignored. It does not restart the frame and does not start a new one afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_a | input | RES_W | First conversion result |
| res_b | input | RES_W | Second conversion result |
| conv_done | input | 1 | One-clock strobe: a new result pair is valid |
| order_b_first | input | 1 | 1 sends `res_b` first |
| sync_inv | input | 1 | 1 makes the frame signal active low |
| sclk_inv | input | 1 | 1 swaps the update and sample edges of the serial clock |
| ext_clk_mode | input | 1 | 1 takes the serial clock from `sclk_in` |
| overlap_read | input | 1 | Read mode with the internal clock: 1 sends the held pair at once, 0 waits for the next conversion |
| chain_in | input | 1 | Serial data from the next device in a chain (external clock only) |
| read_req | input | 1 | One-clock request to start a read |
| sclk_in | input | 1 | External serial clock |
| sdout | output | 1 | Serial data |
| sclk_out | output | 1 | Generated serial clock |
| sync_out | output | 1 | Frame signal |
| read_done | output | 1 | One-clock pulse at the end of a read |

## Verification
The bench uses the default parameters: `RES_W` = 16, `DIV` = 4 and a two-stage synchroniser. A frame therefore takes 128 system clocks, which is short enough to check every clock of several frames and both inversion settings for the internal clock. The slave runs cover 40 update edges, which puts chained bits on `sdout` after the 32-bit frame has gone out. The channel-order table and the mid-frame pulse at bit 16 are checked against values the bench computes itself.

// File: rtl/ser_out_pkg.sv
package ser_out_pkg;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } clk_src_e;

  // level on a pin whose asserted sense is selectable
  function automatic logic pin_level(input logic asserted, input logic invert);
    return asserted ^ invert;
  endfunction

  // one-cycle detection of a low-to-high change
  function automatic logic rise_of(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

endpackage

// File: rtl/sclk_master_gen.sv
module sclk_master_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic bit_tick,
  output logic phase_hi
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_tick = run && (cnt_q == LAST);
  assign phase_hi = (cnt_q < HALF);

endmodule

// File: rtl/sclk_slave_sync.sv
module sclk_slave_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic invert,
  output logic upd_tick
);
  import ser_out_pkg::*;

  logic [STAGES:0] pipe_q;

  genvar gi;
  generate
    for (gi = 0; gi <= STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[gi] <= 1'b0;
          else        pipe_q[gi] <= sclk_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[gi] <= 1'b0;
          else        pipe_q[gi] <= pipe_q[gi-1];
        end
      end
    end
  endgenerate

  assign upd_tick = rise_of(pin_level(pipe_q[STAGES-1], invert),
                            pin_level(pipe_q[STAGES], invert));

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [W-1:0]               load_data,
  input  logic                       shift,
  input  logic                       chain_bit,
  output logic                       msb,
  output logic [$clog2(W+1)-1:0]     bit_cnt
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0] sreg_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      sreg_q <= load_data;
      cnt_q  <= '0;
    end else if (shift) begin
      sreg_q <= {sreg_q[W-2:0], chain_bit};
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign msb     = sreg_q[W-1];
  assign bit_cnt = cnt_q;

endmodule

// File: rtl/dual_result_serializer.sv
module dual_result_serializer #(
  parameter int RES_W       = 16,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] res_a,
  input  logic [RES_W-1:0] res_b,
  input  logic             conv_done,
  input  logic             order_b_first,
  input  logic             sync_inv,
  input  logic             sclk_inv,
  input  logic             ext_clk_mode,
  input  logic             overlap_read,
  input  logic             chain_in,
  input  logic             read_req,
  input  logic             sclk_in,
  output logic             sdout,
  output logic             sclk_out,
  output logic             sync_out,
  output logic             read_done
);
  import ser_out_pkg::*;

  localparam int FRAME_W = 2 * RES_W;
  localparam int CW      = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_W - 1);
  localparam logic [CW-1:0] GAP_BIT  = CW'(RES_W);

  function automatic logic [FRAME_W-1:0] order_pair(
    input logic [RES_W-1:0] a,
    input logic [RES_W-1:0] b,
    input logic             b_first
  );
    return b_first ? {b, a} : {a, b};
  endfunction

  clk_src_e src;
  assign src = clk_src_e'(ext_clk_mode);

  // held pair, always stored as {a, b}
  logic [FRAME_W-1:0] hold_q;
  logic [FRAME_W-1:0] src_pair;
  logic               pending_q;
  logic               frame_active;
  logic               done_q;

  // named internal events
  logic start_master, start_slave, load_w;
  logic bit_tick, phase_hi, upd_tick, shift_en, last_shift;
  logic msb;
  logic [CW-1:0] bit_cnt;

  assign src_pair = conv_done ? {res_a, res_b} : hold_q;

  assign start_master = (src == SRC_INTERNAL) && !frame_active &&
                        ((overlap_read && read_req) ||
                         (!overlap_read && conv_done && (pending_q || read_req)));
  assign start_slave  = (src == SRC_EXTERNAL) && read_req;
  assign load_w       = start_master || start_slave;

  assign shift_en   = frame_active && ((src == SRC_EXTERNAL) ? upd_tick : bit_tick);
  assign last_shift = shift_en && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (conv_done) begin
      hold_q <= {res_a, res_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else if (load_w || overlap_read || (src == SRC_EXTERNAL)) begin
      pending_q <= 1'b0;
    end else if (read_req && !frame_active) begin
      pending_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_active <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      done_q <= last_shift && !load_w;
      if (load_w) begin
        frame_active <= 1'b1;
      end else if (last_shift && (src == SRC_INTERNAL)) begin
        frame_active <= 1'b0;
      end
    end
  end

  sclk_master_gen #(.DIV(DIV)) u_mgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (frame_active && (src == SRC_INTERNAL)),
    .restart  (load_w),
    .bit_tick (bit_tick),
    .phase_hi (phase_hi)
  );

  sclk_slave_sync #(.STAGES(SYNC_STAGES)) u_ssync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_in  (sclk_in),
    .invert   (sclk_inv),
    .upd_tick (upd_tick)
  );

  frame_shifter #(.W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_w),
    .load_data (order_pair(src_pair[FRAME_W-1:RES_W], src_pair[RES_W-1:0], order_b_first)),
    .shift     (shift_en),
    .chain_bit (chain_in),
    .msb       (msb),
    .bit_cnt   (bit_cnt)
  );

  logic master_on;
  assign master_on = frame_active && (src == SRC_INTERNAL);

  assign sdout     = frame_active ? msb : 1'b0;
  assign sclk_out  = pin_level(master_on && phase_hi, sclk_inv);
  assign sync_out  = pin_level(master_on && (bit_cnt != GAP_BIT), sync_inv);
  assign read_done = done_q;

endmodule

// File: rtl/dual_result_serializer_chk.sv
module dual_result_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_clk_mode,
  input logic sync_inv,
  input logic frame_active,
  input logic load_w,
  input logic bit_tick,
  input logic upd_tick,
  input logic sdout,
  input logic sync_out,
  input logic read_done
);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    read_done |=> !read_done);

  assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done && !ext_clk_mode) |-> (sdout == 1'b0));

  assert_sync_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done && !ext_clk_mode) |-> (sync_out == sync_inv));

  assert_master_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_mode && $stable(ext_clk_mode) && frame_active && $past(frame_active)
     && !$past(bit_tick)) |-> $stable(sdout));

  assert_slave_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk_mode && $stable(ext_clk_mode) && frame_active && $past(frame_active)
     && !$past(upd_tick) && !$past(load_w)) |-> $stable(sdout));

endmodule

bind dual_result_serializer dual_result_serializer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ext_clk_mode (ext_clk_mode),
  .sync_inv     (sync_inv),
  .frame_active (frame_active),
  .load_w       (load_w),
  .bit_tick     (bit_tick),
  .upd_tick     (upd_tick),
  .sdout        (sdout),
  .sync_out     (sync_out),
  .read_done    (read_done)
);

// File: tb/dual_result_serializer_bench.sv
`timescale 1ns/1ps
module dual_result_serializer_bench;

  localparam int RW   = 16;
  localparam int FW   = 2 * RW;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] res_a = '0, res_b = '0;
  logic conv_done = 0, order_b_first = 0, sync_inv = 0, sclk_inv = 0;
  logic ext_clk_mode = 0, overlap_read = 1, chain_in = 0, read_req = 0, sclk_in = 1;
  wire sdout, sclk_out, sync_out, read_done;

  int checks = 0, fails = 0, done_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) if (read_done === 1'b1) done_cnt++;

  dual_result_serializer #(.RES_W(RW), .DIV(DIV), .SYNC_STAGES(2)) u_dual_result_serializer (
    .clk(clk), .rst_n(rst_n), .res_a(res_a), .res_b(res_b), .conv_done(conv_done),
    .order_b_first(order_b_first), .sync_inv(sync_inv), .sclk_inv(sclk_inv),
    .ext_clk_mode(ext_clk_mode), .overlap_read(overlap_read), .chain_in(chain_in),
    .read_req(read_req), .sclk_in(sclk_in), .sdout(sdout), .sclk_out(sclk_out),
    .sync_out(sync_out), .read_done(read_done)
  );

  // {a, b, order_b_first, sync_inv, sclk_inv}
  localparam logic [2*RW+2:0] VEC [6] = '{
    {16'hA5C3, 16'h3C5A, 1'b0, 1'b0, 1'b0},
    {16'hA5C3, 16'h3C5A, 1'b1, 1'b0, 1'b0},
    {16'hFFFF, 16'h0000, 1'b0, 1'b1, 1'b0},
    {16'h0001, 16'h8000, 1'b1, 1'b0, 1'b1},
    {16'h1234, 16'hFEDC, 1'b0, 1'b1, 1'b1},
    {16'h8001, 16'h7FFE, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench's own frame assembly, bit by bit
  function automatic logic [FW-1:0] build_frame(input logic [RW-1:0] a, b, input logic bf);
    logic [FW-1:0] f;
    for (int i = 0; i < RW; i++) begin
      f[FW-1-i] = bf ? b[RW-1-i] : a[RW-1-i];
      f[RW-1-i] = bf ? a[RW-1-i] : b[RW-1-i];
    end
    return f;
  endfunction

  // caller drives the start strobe at a negedge just before calling
  task automatic master_frame(input logic [FW-1:0] expf, input logic sinv, input logic kinv,
                              input bit inject, input logic [RW-1:0] na, input logic [RW-1:0] nb,
                              input string tag);
    int sd_bad = 0, ck_bad = 0, sy_bad = 0;
    logic [FW-1:0] obs = '0;
    logic mid = 1'b0;
    @(posedge clk);
    for (int k = 0; k < FW; k++) begin
      for (int c = 0; c < DIV; c++) begin
        @(negedge clk);
        read_req = 0; conv_done = 0;
        if (sdout !== expf[FW-1-k]) sd_bad++;
        if (c == HALF) obs[FW-1-k] = sdout;
        if (sclk_out !== (((c < HALF) ? 1'b1 : 1'b0) ^ kinv)) ck_bad++;
        if (sync_out !== (((k != RW) ? 1'b1 : 1'b0) ^ sinv)) sy_bad++;
        if (k == RW && c == 0) mid = sync_out;
        if (inject && k == 5 && c == 1) begin
          res_a = na; res_b = nb; conv_done = 1; read_req = 1;
        end
      end
    end
    @(negedge clk);
    read_req = 0; conv_done = 0;
    chk(obs === expf, {"R2 frame order ", tag}, obs, expf);
    chk(sd_bad == 0, {"R3 sdout per clock ", tag}, sd_bad, 0);
    chk(ck_bad == 0, {"R3 sclk waveform ", tag}, ck_bad, 0);
    chk(sy_bad == 0, {"R4 sync framing ", tag}, sy_bad, 0);
    chk(mid === sinv, {"R5 mid-frame pulse ", tag}, mid, sinv);
    chk(read_done === 1'b1, {"R10 done after last bit ", tag}, read_done, 1);
    chk(sdout === 1'b0, {"R11 idle low at done ", tag}, sdout, 0);
    chk(sync_out === sinv && sclk_out === kinv, {"R4 idle levels ", tag}, {sync_out, sclk_out}, {sinv, kinv});
    @(negedge clk);
    chk(read_done === 1'b0, {"R10 one-clock done ", tag}, read_done, 0);
  endtask

  task automatic slave_frame(input logic [FW-1:0] expf, input logic kinv, input logic [15:0] chain_pat,
                             input string tag);
    int bad = 0, hold_bad = 0, d0;
    logic e;
    @(negedge clk);
    sclk_inv = kinv; sclk_in = ~kinv;
    repeat (6) @(negedge clk);
    read_req = 1;
    @(negedge clk);
    read_req = 0;
    d0 = done_cnt;
    repeat (2) @(negedge clk);
    chk(sdout === expf[FW-1], {"R8 first bit after load ", tag}, sdout, expf[FW-1]);
    for (int j = 1; j <= 40; j++) begin
      // sample edge: no change expected
      sclk_in = kinv;
      repeat (4) @(negedge clk);
      e = (j - 1 < FW) ? expf[FW-j] : chain_pat[j-1-FW];
      if (sdout !== e) hold_bad++;
      chain_in = chain_pat[j-1];
      sclk_in = ~kinv;
      repeat (4) @(negedge clk);
      e = (j < FW) ? expf[FW-1-j] : chain_pat[j-FW];
      if (sdout !== e) bad++;
    end
    chk(bad == 0, {"R8 R9 update-edge data and chain ", tag}, bad, 0);
    chk(hold_bad == 0, {"R8 sample edge holds ", tag}, hold_bad, 0);
    chk(done_cnt - d0 == 1, {"R10 slave done count ", tag}, done_cnt - d0, 1);
    chk(sync_out === sync_inv, {"R4 sync idle in slave ", tag}, sync_out, sync_inv);
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sdout === 0 && read_done === 0, "R1 reset outputs", {sdout, read_done}, 0);
    chk(sync_out === 0 && sclk_out === 0, "R1 reset pin levels", {sync_out, sclk_out}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // table of master frames, overlap read mode
    for (int v = 0; v < 6; v++) begin
      res_a = VEC[v][2*RW+2:RW+3]; res_b = VEC[v][RW+2:3];
      order_b_first = VEC[v][2]; sync_inv = VEC[v][1]; sclk_inv = VEC[v][0];
      conv_done = 1;
      @(negedge clk);
      conv_done = 0;
      @(negedge clk);
      read_req = 1;
      master_frame(build_frame(VEC[v][2*RW+2:RW+3], VEC[v][RW+2:3], VEC[v][2]),
                   VEC[v][1], VEC[v][0], 0, '0, '0, $sformatf("vec%0d", v));
    end

    // R6 / R12: new conversion and extra read request during a frame
    order_b_first = 0; sync_inv = 0; sclk_inv = 0;
    res_a = 16'hC0DE; res_b = 16'h0BAD; conv_done = 1;
    @(negedge clk);
    conv_done = 0;
    @(negedge clk);
    read_req = 1;
    master_frame(build_frame(16'hC0DE, 16'h0BAD, 0), 0, 0, 1, 16'h1357, 16'h9BDF, "R6 old pair kept");
    repeat (6) @(negedge clk);
    chk(sdout === 0 && sync_out === 0, "R12 no restart after ignored request", {sdout, sync_out}, 0);
    read_req = 1;
    master_frame(build_frame(16'h1357, 16'h9BDF, 0), 0, 0, 0, '0, '0, "R6 new pair next read");

    // R7: wait for conversion
    overlap_read = 0; order_b_first = 1;
    read_req = 1;
    @(negedge clk);
    read_req = 0;
    repeat (8) @(negedge clk);
    chk(sdout === 0 && sync_out === 0 && read_done === 0, "R7 idle while waiting",
        {sdout, sync_out, read_done}, 0);
    res_a = 16'h4E21; res_b = 16'hB7D0; conv_done = 1;
    master_frame(build_frame(16'h4E21, 16'hB7D0, 1), 0, 0, 0, '0, '0, "R7 waited frame");
    overlap_read = 1;

    // slave mode, both clock senses
    ext_clk_mode = 1; order_b_first = 0;
    slave_frame(build_frame(16'h4E21, 16'hB7D0, 0), 0, 16'hB5A3, "slave rise");
    order_b_first = 1;
    slave_frame(build_frame(16'h4E21, 16'hB7D0, 1), 1, 16'h3C69, "slave fall");

    // reset in the middle of a chained stream
    rst_n = 0;
    @(negedge clk);
    chk(sdout === 0 && sclk_out === sclk_inv && sync_out === sync_inv, "R1 reset mid-read",
        {sdout, sclk_out, sync_out}, {1'b0, sclk_inv, sync_inv});
    rst_n = 1;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule